// File: doc/BRIEF.md
# Multi-Channel Clock Crossbar Controller

The block drives up to sixteen independent output clocks from four shared source clocks. For every channel, software picks one of the sources, divides it by 1, 2, 4 or 8, and may switch the channel off. All channels take their settings from three packed 32-bit registers: one disable bit per channel, a 2-bit source field per channel and a 2-bit divide exponent per channel. A small synchronous write port and a combinational read port on `clk_i` reach the registers.

Each channel runs a free-running 3-bit phase counter on its selected source. The divided clock is one bit of that counter. The channel copies new settings from the registers only on a falling edge of its current source at which the counter reads zero. At that edge every divided tap is low, so a new divide ratio or a disable never cuts a high pulse short. A setting therefore reaches the output at most eight periods of the current source after the register write. The register values are assumed to stay steady while a channel takes them in.

Top module: `clk_xbar`

## Requirements
- R1: The block has N_CH (default 16) channels, each with its own output bit. Changing the fields of one channel never alters the frequency of another channel.
- R2: On a rising `clk_i` edge with `reg_we_i` high, `reg_wdata_i` is stored in the disable register at byte offset 0x0, the source register at 0x4 or the exponent register at 0x8. `reg_rdata_o` returns, without a clock edge, all 32 bits last written to the register at the offset on `reg_addr_i`.
- R3: Writes to any other offset, including the misaligned offsets 0x1, 0x5 and 0x9 and the offset 0xC, change no register and no output. Reads of those offsets return zero.
- R4: While `rst_ni` is low, all three registers clear to zero. After reset every channel is enabled, uses source 0 and does not divide, so its output follows `src_clk_i[0]`.
- R5: Bit i of the disable register set to 1 holds `chan_clk_o[i]` low, at the latest eight periods of the channel's current source after the write. Set to 0, the bit lets the channel run.
- R6: Bits [2i+1:2i] of the source register hold the index k of the source for channel i. Channel i then runs from `src_clk_i[k]`.
- R7: Bits [2i+1:2i] of the exponent register hold e, and channel i runs at the source frequency divided by 2^e. With e = 0 the output is the source itself. With e >= 1 the output is bit e-1 of a 3-bit counter that increments on every rising source edge, which gives a 50% duty cycle.
- R8: A channel takes new settings only on a falling edge of its current source at which its phase counter is zero. When the exponent switches between nonzero values, every high pulse is therefore at least as long as the smaller ratio's high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| src_clk_i | input | 4 | Source clocks, index matches the source field value |
| chan_clk_o | output | 16 | Channel output clocks |

## Verification
The bench counts output edges over a fixed window, so a wrong field slice, a swapped source index or an off-by-one exponent shows up as a wrong frequency on a specific channel rather than as a subtle phase error. Misaligned and unmapped writes are aimed at decoders that ignore the low address bits; such a decoder would overwrite a live register and stop or retime every channel. The exponent is toggled between 4 and 8 at uneven intervals while the shortest high pulse is recorded; a channel that switched on any edge would show a high pulse far shorter than two source periods. A disable issued on a divided channel must pull the output low within eight source periods; a gate that was ignored or wired to the wrong bit would leave the clock running.

// File: rtl/clk_xbar_pkg.sv
package clk_xbar_pkg;

  localparam int SEL_W = 2;
  localparam int N_SRC = 1 << SEL_W;
  localparam int EXP_W = 2;

  localparam int OFS_GATE = 'h0;
  localparam int OFS_SEL  = 'h4;
  localparam int OFS_DIV  = 'h8;

  typedef struct packed {
    logic             off;
    logic [SEL_W-1:0] sel;
    logic [EXP_W-1:0] exp;
  } ch_cfg_t;

endpackage

// File: rtl/clk_xbar_regs.sv
module clk_xbar_regs
  import clk_xbar_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ch_cfg_t           cfg_o [N_CH]
);

  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(OFS_GATE);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_SEL);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_DIV);

  logic [DATA_W-1:0] gate_q, sel_q, div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      sel_q  <= '0;
      div_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_GATE) gate_q <= wdata_i;
      if (addr_i == A_SEL)  sel_q  <= wdata_i;
      if (addr_i == A_DIV)  div_q  <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_GATE) rdata_o = gate_q;
    if (addr_i == A_SEL)  rdata_o = sel_q;
    if (addr_i == A_DIV)  rdata_o = div_q;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_cfg
    assign cfg_o[i].off = gate_q[i];
    assign cfg_o[i].sel = sel_q[SEL_W*i +: SEL_W];
    assign cfg_o[i].exp = div_q[EXP_W*i +: EXP_W];
  end

  assert_wr_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_GATE) |=> (gate_q == $past(wdata_i)));

  assert_wr_div_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIV) |=> (div_q == $past(wdata_i)));

  assert_bad_ofs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != A_GATE && addr_i != A_SEL && addr_i != A_DIV)
    |=> ($stable(gate_q) && $stable(sel_q) && $stable(div_q)));

endmodule

// File: rtl/clk_xbar_chan.sv
module clk_xbar_chan
  import clk_xbar_pkg::*;
(
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_clk_i,
  input  ch_cfg_t          cfg_i,
  output logic             clk_o
);

  localparam int TAP_N = 1 << EXP_W;
  localparam int CNT_W = TAP_N - 1;

  ch_cfg_t          act_q;
  logic             src_clk;
  logic [CNT_W-1:0] cnt_q;
  logic [TAP_N-1:0] taps;

  assign src_clk = src_clk_i[act_q.sel];

  always_ff @(posedge src_clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // settings land only where every divided tap is low
  always_ff @(negedge src_clk or negedge rst_ni) begin
    if (!rst_ni)           act_q <= '0;
    else if (cnt_q == '0)  act_q <= cfg_i;
  end

  assign taps  = {cnt_q, src_clk};
  assign clk_o = taps[act_q.exp] & ~act_q.off;

  assert_phase0_R8: assert property (@(negedge src_clk) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(act_q));

  assert_half_rate_R7: assert property (@(posedge src_clk) disable iff (!rst_ni)
    ($stable(act_q) && act_q.exp == EXP_W'(1) && !act_q.off)
    |-> (clk_o != $past(clk_o)));

endmodule

// File: rtl/clk_xbar.sv
module clk_xbar
  import clk_xbar_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [N_SRC-1:0]  src_clk_i,
  output logic [N_CH-1:0]   chan_clk_o
);

  ch_cfg_t cfg [N_CH];

  clk_xbar_regs #(
    .N_CH  (N_CH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .cfg_o  (cfg)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    clk_xbar_chan u_chan (
      .rst_ni   (rst_ni),
      .src_clk_i(src_clk_i),
      .cfg_i    (cfg[i]),
      .clk_o    (chan_clk_o[i])
    );
  end

endmodule

// File: tb/clk_xbar_bench.sv
// Time unit taken as 100 ps: clock half period 25 units -> 200 MHz.
module clk_xbar_bench;

  localparam int N_CH     = 16;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int CLK_HALF = 25;
  localparam int SRC_P [4] = '{100, 140, 220, 300};
  localparam int WIN      = 24000;
  localparam int SETTLE   = 6000;
  localparam int WD_LIMIT = 2000000;

  // {disable, source, exponent}
  localparam logic [95:0] VEC [4] = '{
    {32'h0000_0000, 32'hE4E4_E4E4, 32'h0000_0000},
    {32'h0000_A5A5, 32'h1B1B_1B1B, 32'hE4E4_E4E4},
    {32'hFFFF_0000, 32'h55AA_33CC, 32'h1E2D_3C4B},
    {32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'hFFFF_FFFF}
  };

  logic              clk, rst_n, we;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic              s0, s1, s2, s3;
  logic [3:0]        src_clk;
  logic [N_CH-1:0]   chan_clk;

  int          n_chk, n_err;
  bit          done;
  logic [31:0] m_gate, m_sel, m_div;

  assign src_clk = {s3, s2, s1, s0};

  clk_xbar #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_clk_xbar (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .src_clk_i  (src_clk),
    .chan_clk_o (chan_clk)
  );

  initial begin clk = 1'b0; forever #(CLK_HALF) clk = ~clk; end
  initial begin s0 = 1'b0; #1; forever #(SRC_P[0]/2) s0 = ~s0; end
  initial begin s1 = 1'b0; #1; forever #(SRC_P[1]/2) s1 = ~s1; end
  initial begin s2 = 1'b0; #1; forever #(SRC_P[2]/2) s2 = ~s2; end
  initial begin s3 = 1'b0; #1; forever #(SRC_P[3]/2) s3 = ~s3; end

  // edge counters
  logic        clr_cnt, cnt_en;
  logic [15:0] edge_cnt [N_CH];
  for (genvar g = 0; g < N_CH; g++) begin : g_mon
    logic [15:0] n;
    always @(posedge chan_clk[g] or posedge clr_cnt)
      if (clr_cnt)     n <= '0;
      else if (cnt_en) n <= n + 16'd1;
    assign edge_cnt[g] = n;
  end

  // shortest high pulse on channel 3
  logic mon_en;
  real  t_rise, min_hi;
  always @(chan_clk[3]) begin
    if (!mon_en) begin
      t_rise = -1.0;
      min_hi = 1.0e9;
    end else if (chan_clk[3]) begin
      t_rise = $realtime;
    end else if (t_rise >= 0.0 && ($realtime - t_rise) < min_hi) begin
      min_hi = $realtime - t_rise;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 4'h0) m_gate = d;
    if (a == 4'h4) m_sel  = d;
    if (a == 4'h8) m_div  = d;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic check_regs(input string req);
    logic [31:0] d;
    rd(4'h0, d); check(d == m_gate, req, "disable reg", d, m_gate);
    rd(4'h4, d); check(d == m_sel,  req, "source reg",  d, m_sel);
    rd(4'h8, d); check(d == m_div,  req, "exponent reg", d, m_div);
  endtask

  function automatic int exp_edges(input int ch);
    int s, e;
    if (m_gate[ch]) return 0;
    s = int'(m_sel[2*ch +: 2]);
    e = int'(m_div[2*ch +: 2]);
    return WIN / (SRC_P[s] << e);
  endfunction

  task automatic measure(input string req);
    clr_cnt = 1'b1; #1; clr_cnt = 1'b0;
    cnt_en = 1'b1; #(WIN); cnt_en = 1'b0; #1;
    for (int ch = 0; ch < N_CH; ch++) begin
      int a, e;
      a = int'(edge_cnt[ch]);
      e = exp_edges(ch);
      check((a - e) <= 1 && (e - a) <= 1, req, $sformatf("ch%0d edges", ch), a, e);
    end
  endtask

  initial begin
    #(WD_LIMIT);
    if (!done) begin
      n_err++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    clr_cnt = 1'b0; cnt_en = 1'b0; mon_en = 1'b0;
    m_gate = '0; m_sel = '0; m_div = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state
    check_regs("R4");
    #(SETTLE);
    measure("R4");

    // table walk: R1 R2 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      wr(4'h0, VEC[v][95:64]);
      wr(4'h4, VEC[v][63:32]);
      wr(4'h8, VEC[v][31:0]);
      check_regs("R2");
      #(SETTLE);
      measure("R1 R5 R6 R7");
    end

    // R3: unmapped and misaligned offsets
    wr(4'h0, VEC[1][95:64]);
    wr(4'h4, VEC[1][63:32]);
    wr(4'h8, VEC[1][31:0]);
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h5, 32'hFFFF_FFFF);
    wr(4'h9, 32'hFFFF_FFFF);
    check_regs("R3");
    rd(4'hC, d); check(d == 32'h0, "R3", "read 0xC", d, 0);
    rd(4'h1, d); check(d == 32'h0, "R3", "read 0x1", d, 0);
    #(SETTLE);
    measure("R3");

    // R8: exponent toggled 2 <-> 3 on channel 3 at uneven times
    m_gate[3] = 1'b0; m_sel[7:6] = 2'd1; m_div[7:6] = 2'd2;
    wr(4'h0, m_gate);
    wr(4'h4, m_sel);
    wr(4'h8, m_div);
    #(SETTLE);
    mon_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      logic [31:0] nd;
      nd = m_div;
      nd[7:6] = (i % 2 == 1) ? 2'd2 : 2'd3;
      wr(4'h8, nd);
      #(300 + 170 * i);
    end
    #(SETTLE);
    check(min_hi >= 279.0 && min_hi < 1.0e8, "R8", "min high pulse",
          longint'($rtoi(min_hi)), 280);
    mon_en = 1'b0;
    measure("R8");

    // R5: disable lands within eight source periods
    m_gate[3] = 1'b1;
    wr(4'h0, m_gate);
    #(8 * SRC_P[1] + 200);
    begin
      int highs;
      highs = 0;
      for (int k = 0; k < 40; k++) begin
        #30;
        if (chan_clk[3]) highs++;
      end
      check(highs == 0, "R5", "ch3 high samples after disable", highs, 0);
    end
    measure("R1 R5");
    m_gate[3] = 1'b0;
    wr(4'h0, m_gate);
    #(SETTLE);
    measure("R5");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule